// File: doc/BRIEF.md
# Key-Guarded Memory Lock Register

This block is one 32-bit control register that decides whether a stand-by memory may be written. The memory starts locked. It can only be opened by three back-to-back register writes that carry an escalating key in a three-bit field, while a separate four-bit field stays clear. A single write of a fixed four-bit code, with the three-bit field clear, closes it again at any time.

The register sits on a simple register bus: a write strobe, an address-decode hit, 32-bit write data and 32-bit read data. Reading the register shows only the lock status in bit 0. Both key fields read back as zero. A write-enable gate passes the memory requester's write enable only while the register shows unlocked. Memory reads are never gated.

Top module: `memlock_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `bus_rdata` is 32'h0 and `unlocked_o` is 0, meaning locked.
- R2: Three accepted register writes in a row unlock the memory. Each has bits [7:4]=4'b0000, and bits [3:1] are 3'b001, then 3'b011, then 3'b111. `unlocked_o` rises only after the third write, never after the first or second.
- R3: A write is invalid if bits [3:1] are non-zero and any bit of [7:4] is set. Such a write never advances the unlock sequence, and the sequence already made is lost.
- R4: Any accepted write that is not the next expected step returns the sequence to its start. If that write is itself 3'b001 with [7:4]=0, it counts as the first step of a new sequence. Bits [31:8] and bit 0 of the write data have no effect.
- R5: A write with [7:4]=4'b1001 and [3:1]=3'b000 sets `unlocked_o` to 0 on the next edge. It also discards any partial unlock sequence.
- R6: A write with [7:4]=4'b1001 and [3:1] non-zero does not lock. The status stays unlocked if it was unlocked.
- R7: `bus_rdata[0]` equals the lock status, with 1 meaning unlocked. Bits [31:1] always read 0.
- R8: The status and sequence update on the clock edge that samples the write. A read in the same cycle as a write returns the status from before that write.
- R9: `mem_we_o` equals `req_we` while unlocked and is 0 while locked.
- R10: Cycles without both `bus_wr` and `bus_sel` high change neither the status nor the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register bus write strobe |
| bus_sel | input | 1 | Address decode hit for this register |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data: bit 0 is status, the rest are zero |
| unlocked_o | output | 1 | Lock status, 1 = unlocked |
| req_we | input | 1 | Write enable from the memory requester |
| mem_we_o | output | 1 | Gated write enable toward the memory |

## Verification
Two functions can act in the same cycle. A lock write can arrive while the sequence tracker is waiting for its final step, and the bench provokes this with a directed sequence. The check is that the lock wins and that a following final-step key does not unlock.

A register write and the read or memory write gating can also meet in one cycle, because every bench cycle drives `req_we` with the write. The bench compares `bus_rdata` and `mem_we_o`, sampled before the edge, against the model's previous status. It compares `unlocked_o` after the edge against the updated status. Constrained-random writes biased toward key values drive both collisions at random points in the sequence as well.

// File: rtl/memlock_pkg.sv
package memlock_pkg;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_UKEY_LSB = 1;
  localparam int unsigned DEF_UKEY_W   = 3;
  localparam int unsigned DEF_LKEY_LSB = 4;
  localparam int unsigned DEF_LKEY_W   = 4;
  localparam logic [3:0]  DEF_LOCK_CODE = 4'b1001;

  // Key for unlock step k (0-based): the low k+1 bits set.
  function automatic logic [31:0] step_key(input int unsigned k);
    logic [31:0] v;
    v = '0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i <= k) v[i] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/memlock_keydec.sv
module memlock_keydec
  import memlock_pkg::*;
#(
  parameter int unsigned UKEY_W    = DEF_UKEY_W,
  parameter int unsigned LKEY_W    = DEF_LKEY_W,
  parameter logic [LKEY_W-1:0] LOCK_CODE = DEF_LOCK_CODE
) (
  input  logic [UKEY_W-1:0] ukey,
  input  logic [LKEY_W-1:0] lkey,
  output logic              lock_hit,
  output logic [UKEY_W-1:0] step_hit
);
  logic lkey_clear;
  logic ukey_clear;

  assign lkey_clear = (lkey == '0);
  assign ukey_clear = (ukey == '0);
  assign lock_hit   = ukey_clear && (lkey == LOCK_CODE);

  for (genvar k = 0; k < UKEY_W; k++) begin : g_step
    localparam logic [31:0] KEY_FULL = step_key(k);
    assign step_hit[k] = lkey_clear && (ukey == KEY_FULL[UKEY_W-1:0]);
  end
endmodule

// File: rtl/memlock_tracker.sv
module memlock_tracker #(
  parameter int unsigned STEPS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic             lock_hit,
  input  logic [STEPS-1:0] step_hit,
  output logic             unlocked_q
);
  localparam int unsigned STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  logic [STEP_W-1:0] seen_q, seen_d;
  logic              unl_d;
  logic              expect_hit;

  // Select the step the tracker waits for.
  always_comb begin
    expect_hit = 1'b0;
    for (int unsigned k = 0; k < STEPS; k++) begin
      if (seen_q == STEP_W'(k)) expect_hit = step_hit[k];
    end
  end

  always_comb begin
    seen_d = seen_q;
    unl_d  = unlocked_q;
    if (wr_hit) begin
      if (lock_hit) begin
        seen_d = '0;
        unl_d  = 1'b0;
      end else if (expect_hit) begin
        if (seen_q == LAST) begin
          seen_d = '0;
          unl_d  = 1'b1;
        end else begin
          seen_d = seen_q + 1'b1;
        end
      end else if (step_hit[0]) begin
        seen_d = STEP_W'(1 % STEPS);
      end else begin
        seen_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q     <= '0;
      unlocked_q <= 1'b0;
    end else begin
      seen_q     <= seen_d;
      unlocked_q <= unl_d;
    end
  end
endmodule

// File: rtl/memlock_wgate.sv
module memlock_wgate (
  input  logic unlocked,
  input  logic req_we,
  output logic mem_we
);
  assign mem_we = req_we & unlocked;
endmodule

// File: rtl/memlock_readfmt.sv
module memlock_readfmt #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              unlocked,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata    = '0;
    rdata[0] = unlocked;
  end
endmodule

// File: rtl/memlock_ctrl.sv
module memlock_ctrl
  import memlock_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned UKEY_LSB = DEF_UKEY_LSB,
  parameter int unsigned UKEY_W   = DEF_UKEY_W,
  parameter int unsigned LKEY_LSB = DEF_LKEY_LSB,
  parameter int unsigned LKEY_W   = DEF_LKEY_W,
  parameter logic [LKEY_W-1:0] LOCK_CODE = DEF_LOCK_CODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              unlocked_o,
  input  logic              req_we,
  output logic              mem_we_o
);
  localparam int unsigned USED_TOP = LKEY_LSB + LKEY_W;

  logic              wr_hit;
  logic [UKEY_W-1:0] ukey;
  logic [LKEY_W-1:0] lkey;
  logic              lock_hit;
  logic [UKEY_W-1:0] step_hit;
  logic              unused_wdata;

  assign wr_hit = bus_wr & bus_sel;
  assign ukey   = bus_wdata[UKEY_LSB +: UKEY_W];
  assign lkey   = bus_wdata[LKEY_LSB +: LKEY_W];
  assign unused_wdata = ^{bus_wdata[DATA_W-1:USED_TOP], bus_wdata[0]};

  memlock_keydec #(
    .UKEY_W(UKEY_W), .LKEY_W(LKEY_W), .LOCK_CODE(LOCK_CODE)
  ) u_keydec (
    .ukey(ukey), .lkey(lkey), .lock_hit(lock_hit), .step_hit(step_hit)
  );

  memlock_tracker #(.STEPS(UKEY_W)) u_tracker (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .lock_hit(lock_hit),
    .step_hit(step_hit), .unlocked_q(unlocked_o)
  );

  memlock_wgate u_wgate (
    .unlocked(unlocked_o), .req_we(req_we), .mem_we(mem_we_o)
  );

  memlock_readfmt #(.DATA_W(DATA_W)) u_readfmt (
    .unlocked(unlocked_o), .rdata(bus_rdata)
  );
endmodule

// File: rtl/memlock_ctrl_chk.sv
module memlock_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic        bus_sel,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        unlocked_o,
  input logic        req_we,
  input logic        mem_we_o
);
  logic wr_hit, lock_wr, final_wr, bad_lock_wr;
  assign wr_hit      = bus_wr && bus_sel;
  assign lock_wr     = wr_hit && bus_wdata[7:4] == 4'b1001 && bus_wdata[3:1] == 3'b000;
  assign final_wr    = wr_hit && bus_wdata[7:4] == 4'b0000 && bus_wdata[3:1] == 3'b111;
  assign bad_lock_wr = wr_hit && bus_wdata[7:4] == 4'b1001 && bus_wdata[3:1] != 3'b000;

  p_unlock_needs_final_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked_o) |-> $past(final_wr));

  p_lock_write_locks_r5: assert property (@(posedge clk) disable iff (rst)
    lock_wr |=> !unlocked_o);

  p_fall_needs_lock_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(unlocked_o) |-> $past(lock_wr));

  p_bad_lock_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (bad_lock_wr && unlocked_o) |=> unlocked_o);

  p_read_shows_status_r7: assert property (@(posedge clk) disable iff (rst)
    bus_rdata == {31'b0, unlocked_o});

  p_gate_closed_r9: assert property (@(posedge clk) disable iff (rst)
    !unlocked_o |-> !mem_we_o);

  p_gate_open_r9: assert property (@(posedge clk) disable iff (rst)
    unlocked_o |-> (mem_we_o == req_we));

  p_idle_bus_holds_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(unlocked_o));
endmodule

bind memlock_ctrl memlock_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unlocked_o(unlocked_o),
  .req_we(req_we), .mem_we_o(mem_we_o)
);

// File: tb/tb_memlock_ctrl.sv
module tb_memlock_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_sel, req_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        unlocked_o, mem_we_o;

  int total = 0;
  int bad   = 0;
  int m_seen = 0;
  bit m_unl  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memlock_ctrl dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unlocked_o(unlocked_o),
    .req_we(req_we), .mem_we_o(mem_we_o)
  );

  function automatic logic [2:0] want_key(input int s);
    return (s == 0) ? 3'b001 : (s == 1) ? 3'b011 : 3'b111;
  endfunction

  task automatic model_write(input logic [31:0] d);
    logic [3:0] lk;
    logic [2:0] uk;
    lk = d[7:4];
    uk = d[3:1];
    if (lk == 4'b1001 && uk == 3'b000) begin
      m_seen = 0; m_unl = 1'b0;
    end else if (lk == 4'b0000 && uk == want_key(m_seen)) begin
      if (m_seen == 2) begin m_seen = 0; m_unl = 1'b1; end
      else m_seen = m_seen + 1;
    end else if (lk == 4'b0000 && uk == 3'b001) begin
      m_seen = 1;
    end else begin
      m_seen = 0;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic sel, input logic [31:0] d,
                     input logic we, input string req);
    @(negedge clk);
    bus_wr = wr; bus_sel = sel; bus_wdata = d; req_we = we;
    #1;
    check({req, " R8 R7 same-cycle read"}, bus_rdata, {31'b0, m_unl});
    check({req, " R9 gate"}, {31'b0, mem_we_o}, {31'b0, we & m_unl});
    @(posedge clk);
    if (wr && sel) model_write(d);
    #1;
    check({req, " status"}, {31'b0, unlocked_o}, {31'b0, m_unl});
  endtask

  task automatic wr(input logic [31:0] d, input string req);
    cyc(1'b1, 1'b1, d, 1'b1, req);
  endtask

  function automatic logic [31:0] mk(input logic [3:0] lk, input logic [2:0] uk);
    return {24'h0, lk, uk, 1'b0};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_sel = 1'b0; bus_wdata = '0; req_we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 status", {31'b0, unlocked_o}, 32'h0);

    // R2: full sequence, locked until the third write
    wr(mk(4'h0, 3'b001), "R2 step1");
    check("R2 still locked after 1", {31'b0, unlocked_o}, 32'h0);
    wr(mk(4'h0, 3'b011), "R2 step2");
    check("R2 still locked after 2", {31'b0, unlocked_o}, 32'h0);
    wr(mk(4'h0, 3'b111), "R2 step3");
    check("R2 unlocked", {31'b0, unlocked_o}, 32'h1);
    cyc(1'b0, 1'b0, '0, 1'b1, "R9 pass when unlocked");

    // R6: lock code with unlock field set is ignored
    wr(mk(4'h9, 3'b001), "R6 bad lock");
    check("R6 stays unlocked", {31'b0, unlocked_o}, 32'h1);

    // R5: lock
    wr(mk(4'h9, 3'b000), "R5 lock");
    check("R5 locked", {31'b0, unlocked_o}, 32'h0);
    cyc(1'b0, 1'b0, '0, 1'b1, "R9 blocked when locked");

    // R3: invalid middle step breaks the sequence
    wr(mk(4'h0, 3'b001), "R3 s1");
    wr(mk(4'h1, 3'b011), "R3 invalid");
    wr(mk(4'h0, 3'b111), "R3 s3");
    check("R3 not unlocked", {31'b0, unlocked_o}, 32'h0);

    // R4: restart on 001, upper bits ignored
    wr(mk(4'h0, 3'b001), "R4 s1");
    wr(mk(4'h0, 3'b011), "R4 s2");
    wr(32'hABCD_E003, "R4 restart with junk upper bits");
    wr(mk(4'h0, 3'b011), "R4 s2b");
    wr(32'h5A5A_5A0F, "R4 s3 with junk upper bits");
    check("R4 unlocked after restart", {31'b0, unlocked_o}, 32'h1);
    wr(mk(4'h9, 3'b000), "R5 relock");
    wr(mk(4'h0, 3'b001), "R4 s1");
    wr(mk(4'h0, 3'b000), "R4 no-op breaks");
    wr(mk(4'h0, 3'b011), "R4 s2 out of order");
    wr(mk(4'h0, 3'b111), "R4 s3 out of order");
    check("R4 still locked", {31'b0, unlocked_o}, 32'h0);

    // R5: lock in the middle of a sequence
    wr(mk(4'h0, 3'b001), "R5 s1");
    wr(mk(4'h0, 3'b011), "R5 s2");
    wr(mk(4'h9, 3'b000), "R5 lock mid-sequence");
    wr(mk(4'h0, 3'b111), "R5 s3 after lock");
    check("R5 sequence discarded", {31'b0, unlocked_o}, 32'h0);

    // R10: non-selected cycles do not disturb the sequence
    wr(mk(4'h0, 3'b001), "R10 s1");
    wr(mk(4'h0, 3'b011), "R10 s2");
    cyc(1'b1, 1'b0, mk(4'h9, 3'b000), 1'b0, "R10 other address");
    cyc(1'b0, 1'b1, mk(4'hF, 3'b101), 1'b1, "R10 no strobe");
    wr(mk(4'h0, 3'b111), "R10 s3");
    check("R10 unlocked", {31'b0, unlocked_o}, 32'h1);
    cyc(1'b1, 1'b0, mk(4'h9, 3'b000), 1'b1, "R10 lock to other address");
    check("R10 still unlocked", {31'b0, unlocked_o}, 32'h1);

    // Random mix, biased toward key values
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int pu, pl;
      logic [2:0] uk;
      logic [3:0] lk;
      logic [31:0] d;
      pu = $urandom_range(0, 9);
      pl = $urandom_range(0, 9);
      uk = (pu < 3) ? 3'b001 : (pu < 5) ? 3'b011 : (pu < 7) ? 3'b111 :
           (pu < 8) ? 3'b000 : 3'($urandom);
      lk = (pl < 7) ? 4'h0 : (pl < 9) ? 4'h9 : 4'($urandom);
      d  = {$urandom_range(0, 255) == 0 ? 24'h0 : 24'($urandom), lk, uk, 1'($urandom)};
      cyc(($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0), d,
          1'($urandom), "R2 R3 R4 R5 R6 R10 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule